// File: doc/BRIEF.md
# Five-Stage In-Order Pipeline Core

A small in-order processor with five stages: fetch, decode, execute, memory and write-back. A one-entry register with a presence bit sits between each pair of neighbouring stages. The core reads 32-bit instruction words from an instruction port and reaches data through a data port in the memory stage. It holds a 16-entry by 32-bit register file. A `start` pulse sets fetch running from address 0. A Halt word stops fetch, and `done` goes high once nothing is left in flight.

Decode swaps every source register index for its value. When an older instruction still in flight will write that register, decode has two choices: stall, or take the value from a later point in the pipeline. The parameter `HAZ_MODE` picks the policy:
- 0: stall only.
- 1: forward from the execute and memory result buffers, but stall on the decode buffer.
- 2: also forward the execute result in the same cycle it is computed.

Both memory ports are plain request ports with no back-pressure. `imem_req` qualifies `imem_addr`, and the word must be present on `imem_data` in that same cycle. `dmem_re`/`dmem_we` qualify `dmem_addr`, and read data must come back in the same cycle. The memories must therefore always be ready.

Top module: `pipe5_core`

## Requirements
- R1: After reset, and until the first `start`, `done`, `imem_req`, `dmem_re` and `dmem_we` are all low and nothing is fetched.
- R2: A `start` pulse seen while the core is idle starts fetch at address 0 in the next cycle. A `start` seen while any instruction is in flight or fetch is running has no effect.
- R3: The word layout is: opcode in [31:28], destination in [27:24], first source in [23:20], second source in [19:16], immediate in [15:0]. The opcodes are 0 Add (rd = rs1 + rs2), 2 Load (rd = mem[rs1]), 3 Store (mem[rs1] = rs2) and 4 LoadC (rd = zero-extended immediate). Any other code except 1 and 15 is a no-op.
- R4: Opcode 15 (Halt) stops fetch. `imem_req` is low in the cycle after the Halt word is fetched, unless an older branch redirects.
- R5: `done` rises when fetch has stopped and all four buffers are empty. It stays high until the next accepted `start`. For a run of N words with no stalls (Halt included), it first reads high N+4 cycles after the start edge.
- R6: Opcode 1 (Jz) is resolved in execute. When R[rs1] is zero, fetch moves to address R[rs2]. The instruction then in decode is discarded, and fetch resumes even if that discarded word was a Halt.
- R7: When R[rs1] of a Jz is non-zero, execution continues with the next sequential word.
- R8: In mode 0, a consumer waits until its producer has written the register file. Each back-to-back dependency costs 3 cycles.
- R9: In mode 1, a consumer takes a value from the execute or memory result buffer. It stalls while the producer sits in the decode buffer, and also while a Load producer sits in the execute result buffer. This costs 1 cycle per back-to-back dependency, or 2 after a Load.
- R10: In mode 2, an Add or LoadC result is forwarded in the cycle it is computed, so back-to-back use costs no cycles. A Load followed by a use still costs 2 cycles.
- R11: A data read and a data write never happen in the same cycle. A Load that follows a Store to the same address returns the stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin fetching at address 0 when idle |
| done | output | 1 | High once a run has completed and the pipeline is empty |
| imem_req | output | 1 | Instruction fetch in this cycle |
| imem_addr | output | IAW | Word address of the fetch |
| imem_data | input | 32 | Instruction word, valid in the same cycle |
| dmem_re | output | 1 | Data read in this cycle |
| dmem_we | output | 1 | Data write in this cycle |
| dmem_addr | output | DAW | Data word address |
| dmem_wdata | output | 32 | Store data |
| dmem_rdata | input | 32 | Load data, valid in the same cycle |

## Verification
Register state can only be observed through Store data and `done` timing. A wrong forwarded operand or a stale register read therefore shows up as a wrong data-port write within about five cycles of the faulty decode. A hazard detector that stalls too much or too little shifts the rise of `done` by a whole number of cycles. For that reason, each program is run on all three policy variants, and both the stored values and the exact completion cycle are compared. A flush that fails to clear the decode buffer leaves a wrong-path Store in data memory. A Halt fetched on a wrong path that is not cancelled makes `done` rise early with data memory left unwritten.

// File: rtl/pipe5_pkg.sv
package pipe5_pkg;
  parameter int unsigned XLEN = 32;
  parameter int unsigned NREG = 16;
  localparam int unsigned RIW  = $clog2(NREG);
  localparam int unsigned IMMW = 16;

  typedef enum logic [3:0] {
    OPC_ADD   = 4'h0,
    OPC_JZ    = 4'h1,
    OPC_LOAD  = 4'h2,
    OPC_STORE = 4'h3,
    OPC_LDC   = 4'h4,
    OPC_HALT  = 4'hF
  } opc_e;

  typedef enum logic [2:0] {K_NOP, K_ADD, K_JZ, K_LOAD, K_STORE, K_LDC} kind_e;

  // decode -> execute: operands already resolved to values
  typedef struct packed {
    kind_e            kind;
    logic             wr;
    logic [RIW-1:0]   rd;
    logic [XLEN-1:0]  a;
    logic [XLEN-1:0]  b;
  } dx_t;

  // execute -> memory: result or address plus store data
  typedef struct packed {
    logic             wr;
    logic             ld;
    logic             st;
    logic [RIW-1:0]   rd;
    logic [XLEN-1:0]  val;
    logic [XLEN-1:0]  sd;
  } xm_t;

  // memory -> write-back: only what the register file needs
  typedef struct packed {
    logic             wr;
    logic [RIW-1:0]   rd;
    logic [XLEN-1:0]  val;
  } mw_t;
endpackage

// File: rtl/pipe5_regfile.sv
module pipe5_regfile
  import pipe5_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [RIW-1:0]  wa,
  input  logic [XLEN-1:0] wd,
  input  logic [RIW-1:0]  ra0,
  input  logic [RIW-1:0]  ra1,
  output logic [XLEN-1:0] rd0,
  output logic [XLEN-1:0] rd1
);
  logic [XLEN-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (we) begin
      regs[wa] <= wd;
    end
  end

  // no write-through: pending writes in the last buffer are covered by the hazard logic
  assign rd0 = regs[ra0];
  assign rd1 = regs[ra1];
endmodule

// File: rtl/pipe5_opnd.sv
module pipe5_opnd
  import pipe5_pkg::*;
#(
  parameter int unsigned MODE = 2
) (
  input  logic            need,
  input  logic [RIW-1:0]  src,
  input  logic [XLEN-1:0] rf_val,
  input  logic            bd_v,
  input  logic            bd_wr,
  input  logic [RIW-1:0]  bd_rd,
  input  logic            bd_ready,
  input  logic [XLEN-1:0] ex_val,
  input  logic            be_v,
  input  logic            be_wr,
  input  logic            be_ld,
  input  logic [RIW-1:0]  be_rd,
  input  logic [XLEN-1:0] be_val,
  input  logic            bm_v,
  input  logic            bm_wr,
  input  logic [RIW-1:0]  bm_rd,
  input  logic [XLEN-1:0] bm_val,
  output logic [XLEN-1:0] val,
  output logic            stall
);
  localparam bit BYP_BUF = (MODE >= 1);
  localparam bit BYP_EX  = (MODE >= 2);

  logic hit_d, hit_e, hit_m;

  assign hit_d = bd_v && bd_wr && (bd_rd == src);
  assign hit_e = be_v && be_wr && (be_rd == src);
  assign hit_m = bm_v && bm_wr && (bm_rd == src);

  // youngest producer wins; search order is decode buffer, execute buffer, memory buffer
  always_comb begin
    val   = rf_val;
    stall = 1'b0;
    if (!BYP_BUF) begin
      stall = need && (hit_d || hit_e || hit_m);
    end else if (hit_d) begin
      if (BYP_EX && bd_ready) val = ex_val;
      else                    stall = need;
    end else if (hit_e) begin
      if (be_ld) stall = need;
      else       val   = be_val;
    end else if (hit_m) begin
      val = bm_val;
    end
  end
endmodule

// File: rtl/pipe5_exec.sv
module pipe5_exec
  import pipe5_pkg::*;
#(
  parameter int unsigned IAW = 8
) (
  input  dx_t             op,
  output xm_t             res,
  output logic            taken,
  output logic [IAW-1:0]  target,
  output logic [XLEN-1:0] fwd_val,
  output logic            fwd_ok
);
  always_comb begin
    res    = '0;
    res.wr = op.wr;
    res.rd = op.rd;
    unique case (op.kind)
      K_ADD:   res.val = op.a + op.b;
      K_LDC:   res.val = op.a;
      K_LOAD:  begin res.ld = 1'b1; res.val = op.a; end
      K_STORE: begin res.st = 1'b1; res.val = op.a; res.sd = op.b; end
      default: res.val = '0;
    endcase
  end

  // ALU and branch parts side by side in one stage
  assign taken   = (op.kind == K_JZ) && (op.a == '0);
  assign target  = op.b[IAW-1:0];
  assign fwd_val = res.val;
  assign fwd_ok  = (op.kind == K_ADD) || (op.kind == K_LDC);
endmodule

// File: rtl/pipe5_core.sv
module pipe5_core
  import pipe5_pkg::*;
#(
  parameter int unsigned IAW      = 8,
  parameter int unsigned DAW      = 8,
  parameter int unsigned HAZ_MODE = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  output logic            done,
  output logic            imem_req,
  output logic [IAW-1:0]  imem_addr,
  input  logic [31:0]     imem_data,
  output logic            dmem_re,
  output logic            dmem_we,
  output logic [DAW-1:0]  dmem_addr,
  output logic [XLEN-1:0] dmem_wdata,
  input  logic [XLEN-1:0] dmem_rdata
);
  localparam int unsigned NSRC = 2;

  // fetch state and stage buffers
  logic            running, started;
  logic [IAW-1:0]  pc;
  logic            bf_v, bd_v, be_v, bm_v;
  logic [31:0]     bf_w;
  dx_t             bd;
  xm_t             be;
  mw_t             bm;

  // decode fields
  logic [3:0]      f_op;
  logic [RIW-1:0]  f_rd;
  logic [IMMW-1:0] f_imm;
  logic [RIW-1:0]  src_idx  [NSRC];
  logic [XLEN-1:0] rf_val   [NSRC];
  logic [XLEN-1:0] opnd_val [NSRC];
  logic [NSRC-1:0] need, opnd_stall;
  dx_t             dec_out;
  logic            dec_stall, dec_fire;

  // execute / memory
  xm_t             ex_out;
  logic            ex_taken, ex_fwd_ok, redirect;
  logic [IAW-1:0]  ex_target;
  logic [XLEN-1:0] ex_fwd_val;
  mw_t             mem_out;

  logic            fetch_go, active, accept_start, halt_word;

  assign f_op       = bf_w[31:28];
  assign f_rd       = bf_w[27:24];
  assign src_idx[0] = bf_w[23:20];
  assign src_idx[1] = bf_w[19:16];
  assign f_imm      = bf_w[15:0];

  pipe5_regfile u_rf (
    .clk (clk),
    .rst_n (rst_n),
    .we  (bm_v && bm.wr),
    .wa  (bm.rd),
    .wd  (bm.val),
    .ra0 (src_idx[0]),
    .ra1 (src_idx[1]),
    .rd0 (rf_val[0]),
    .rd1 (rf_val[1])
  );

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    pipe5_opnd #(.MODE(HAZ_MODE)) u_sel (
      .need     (need[g]),
      .src      (src_idx[g]),
      .rf_val   (rf_val[g]),
      .bd_v     (bd_v),
      .bd_wr    (bd.wr),
      .bd_rd    (bd.rd),
      .bd_ready (ex_fwd_ok),
      .ex_val   (ex_fwd_val),
      .be_v     (be_v),
      .be_wr    (be.wr),
      .be_ld    (be.ld),
      .be_rd    (be.rd),
      .be_val   (be.val),
      .bm_v     (bm_v),
      .bm_wr    (bm.wr),
      .bm_rd    (bm.rd),
      .bm_val   (bm.val),
      .val      (opnd_val[g]),
      .stall    (opnd_stall[g])
    );
  end

  // decode: class, destination and which sources are read
  always_comb begin
    dec_out    = '0;
    dec_out.rd = f_rd;
    dec_out.a  = opnd_val[0];
    dec_out.b  = opnd_val[1];
    need       = '0;
    case (f_op)
      OPC_ADD:   begin dec_out.kind = K_ADD;   dec_out.wr = 1'b1; need = 2'b11; end
      OPC_JZ:    begin dec_out.kind = K_JZ;    need = 2'b11; end
      OPC_LOAD:  begin dec_out.kind = K_LOAD;  dec_out.wr = 1'b1; need = 2'b01; end
      OPC_STORE: begin dec_out.kind = K_STORE; need = 2'b11; end
      OPC_LDC:   begin
        dec_out.kind = K_LDC;
        dec_out.wr   = 1'b1;
        dec_out.a    = {{(XLEN-IMMW){1'b0}}, f_imm};
      end
      default:   dec_out.kind = K_NOP;
    endcase
  end

  assign dec_stall = bf_v && (|opnd_stall);
  assign dec_fire  = bf_v && !dec_stall && !redirect;

  pipe5_exec #(.IAW(IAW)) u_ex (
    .op      (bd),
    .res     (ex_out),
    .taken   (ex_taken),
    .target  (ex_target),
    .fwd_val (ex_fwd_val),
    .fwd_ok  (ex_fwd_ok)
  );

  assign redirect = bd_v && ex_taken;

  // memory stage
  assign dmem_re    = be_v && be.ld;
  assign dmem_we    = be_v && be.st;
  assign dmem_addr  = be.val[DAW-1:0];
  assign dmem_wdata = be.sd;

  always_comb begin
    mem_out     = '0;
    mem_out.wr  = be.wr;
    mem_out.rd  = be.rd;
    mem_out.val = be.ld ? dmem_rdata : be.val;
  end

  // fetch control
  assign fetch_go     = running && !redirect && (!bf_v || dec_fire);
  assign imem_req     = fetch_go;
  assign imem_addr    = pc;
  assign halt_word    = (imem_data[31:28] == OPC_HALT);
  assign active       = running || bf_v || bd_v || be_v || bm_v;
  assign accept_start = start && !active;
  assign done         = started && !active;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running <= 1'b0;
      started <= 1'b0;
      pc      <= '0;
      bf_v    <= 1'b0;
      bf_w    <= '0;
      bd_v    <= 1'b0;
      bd      <= '0;
      be_v    <= 1'b0;
      be      <= '0;
      bm_v    <= 1'b0;
      bm      <= '0;
    end else begin
      bm_v <= be_v;
      bm   <= mem_out;
      be_v <= bd_v;
      be   <= ex_out;
      bd_v <= dec_fire;
      if (dec_fire) bd <= dec_out;

      if (redirect) begin
        bf_v    <= 1'b0;
        pc      <= ex_target;
        running <= 1'b1;
      end else if (fetch_go) begin
        bf_v <= 1'b1;
        bf_w <= imem_data;
        pc   <= pc + 1'b1;
        if (halt_word) running <= 1'b0;
      end else if (dec_fire) begin
        bf_v <= 1'b0;
      end

      if (accept_start) begin
        running <= 1'b1;
        started <= 1'b1;
        pc      <= '0;
      end
    end
  end
endmodule

// File: rtl/pipe5_core_chk.sv
module pipe5_core_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        done,
  input logic        imem_req,
  input logic [3:0]  imem_op,
  input logic        dmem_re,
  input logic        dmem_we,
  input logic        started,
  input logic        bf_v,
  input logic        bd_v,
  input logic [31:0] bf_w,
  input logic        redirect,
  input logic        dec_stall
);
  assert_idle_before_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !started |-> (!imem_req && !done));

  assert_halt_stops_fetch_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (imem_req && imem_op == 4'hF) |=> !imem_req);

  assert_done_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!imem_req && !dmem_re && !dmem_we));

  assert_redirect_flush_R6: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |=> (!bf_v && !bd_v));

  // R8 R9 R10: a stalled decode keeps its word untouched
  assert_stall_holds_word_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bf_v && dec_stall && !redirect) |=> (bf_v && $stable(bf_w)));

  assert_mem_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(dmem_re && dmem_we));
endmodule

bind pipe5_core pipe5_core_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .done      (done),
  .imem_req  (imem_req),
  .imem_op   (imem_data[31:28]),
  .dmem_re   (dmem_re),
  .dmem_we   (dmem_we),
  .started   (started),
  .bf_v      (bf_v),
  .bd_v      (bd_v),
  .bf_w      (bf_w),
  .redirect  (redirect),
  .dec_stall (dec_stall)
);

// File: tb/pipe5_core_tb_top.sv
`timescale 1ns/1ps
module pipe5_core_tb_top;
  import pipe5_pkg::*;

  localparam int AW = 6;
  localparam int MW = 1 << AW;
  localparam int NV = 3;   // index 0: mode 0, 1: mode 1, 2: mode 2
  localparam logic [31:0] SENT = 32'hDEAD_BEEF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  always #2 clk = ~clk;

  logic [NV-1:0] done_w, ireq_w, dre_w, dwe_w;
  logic [AW-1:0] ia [NV];
  logic [AW-1:0] da [NV];
  logic [31:0]   id [NV];
  logic [31:0]   wd [NV];
  logic [31:0]   rdat [NV];
  logic [31:0]   im [MW];
  logic [31:0]   dm [NV][MW];

  int nchk = 0;
  int nerr = 0;
  int cyc [NV];
  int reqc [NV];
  int faddr [NV];

  always_comb begin
    for (int k = 0; k < NV; k++) begin
      id[k]   = im[ia[k]];
      rdat[k] = dm[k][da[k]];
    end
  end

  always @(posedge clk) begin
    for (int k = 0; k < NV; k++)
      if (dwe_w[k]) dm[k][da[k]] <= wd[k];
  end

  pipe5_core #(.IAW(AW), .DAW(AW), .HAZ_MODE(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .done(done_w[2]),
    .imem_req(ireq_w[2]), .imem_addr(ia[2]), .imem_data(id[2]),
    .dmem_re(dre_w[2]), .dmem_we(dwe_w[2]), .dmem_addr(da[2]),
    .dmem_wdata(wd[2]), .dmem_rdata(rdat[2]));

  pipe5_core #(.IAW(AW), .DAW(AW), .HAZ_MODE(1)) dut_b (
    .clk(clk), .rst_n(rst_n), .start(start), .done(done_w[1]),
    .imem_req(ireq_w[1]), .imem_addr(ia[1]), .imem_data(id[1]),
    .dmem_re(dre_w[1]), .dmem_we(dwe_w[1]), .dmem_addr(da[1]),
    .dmem_wdata(wd[1]), .dmem_rdata(rdat[1]));

  pipe5_core #(.IAW(AW), .DAW(AW), .HAZ_MODE(0)) dut_s (
    .clk(clk), .rst_n(rst_n), .start(start), .done(done_w[0]),
    .imem_req(ireq_w[0]), .imem_addr(ia[0]), .imem_data(id[0]),
    .dmem_re(dre_w[0]), .dmem_we(dwe_w[0]), .dmem_addr(da[0]),
    .dmem_wdata(wd[0]), .dmem_rdata(rdat[0]));

  function automatic logic [31:0] ins(logic [3:0] op, int rd, int s1, int s2, int imm);
    return {op, 4'(rd), 4'(s1), 4'(s2), 16'(imm)};
  endfunction

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < MW; i++) begin
      im[i] = ins(OPC_HALT, 0, 0, 0, 0);
      for (int k = 0; k < NV; k++) dm[k][i] = SENT;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    start = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // pulse start, then count cycles until each variant reports done
  task automatic launch(int restart_at);
    for (int k = 0; k < NV; k++) begin cyc[k] = 0; reqc[k] = 0; end
    @(negedge clk);
    start = 1'b1;
    @(posedge clk);
    #1;
    start = 1'b0;
    for (int k = 0; k < NV; k++) begin faddr[k] = int'(ia[k]); reqc[k] = int'(ireq_w[k]); end
    for (int c = 1; c <= 120; c++) begin
      @(posedge clk);
      #1;
      for (int k = 0; k < NV; k++) begin
        if (ireq_w[k]) reqc[k]++;
        if (done_w[k] && cyc[k] == 0) cyc[k] = c;
      end
      start = (c == restart_at);
      if (cyc[0] != 0 && cyc[1] != 0 && cyc[2] != 0) break;
    end
    start = 1'b0;
  endtask

  task automatic test_reset();
    do_reset();
    #1;
    chk("R1 done after reset", 32'(done_w), 0);
    chk("R1 imem_req after reset", 32'(ireq_w), 0);
    chk("R1 dmem strobes after reset", 32'(dre_w | dwe_w), 0);
    repeat (5) @(posedge clk);
    #1;
    chk("R1 no fetch without start", 32'(ireq_w), 0);
    chk("R1 done stays low without start", 32'(done_w), 0);
  endtask

  task automatic test_halt();
    clear_mem();
    im[0] = ins(OPC_LDC, 1, 0, 0, 1);
    im[1] = ins(OPC_HALT, 0, 0, 0, 0);
    do_reset();
    launch(0);
    for (int k = 0; k < NV; k++) begin
      chk($sformatf("R2 first fetch address v%0d", k), 32'(faddr[k]), 0);
      chk($sformatf("R4 fetch count up to Halt v%0d", k), 32'(reqc[k]), 2);
      chk($sformatf("R5 done cycle two-word run v%0d", k), 32'(cyc[k]), 6);
    end
    repeat (3) @(posedge clk);
    #1;
    chk("R5 done holds after run", 32'(done_w), 32'h7);
  endtask

  task automatic load_chain();
    clear_mem();
    im[0] = ins(OPC_LDC, 1, 0, 0, 5);
    im[1] = ins(OPC_LDC, 2, 0, 0, 7);
    im[2] = ins(OPC_ADD, 3, 1, 2, 0);
    im[3] = ins(OPC_STORE, 0, 0, 3, 0);
    im[4] = ins(OPC_HALT, 0, 0, 0, 0);
  endtask

  task automatic test_chain(int restart_at);
    int exp_c [NV];
    exp_c[0] = 15; exp_c[1] = 11; exp_c[2] = 9;
    load_chain();
    do_reset();
    launch(restart_at);
    for (int k = 0; k < NV; k++) begin
      chk($sformatf("R3 Add result stored v%0d restart=%0d", k, restart_at), dm[k][0], 32'd12);
      chk($sformatf("R8 R9 R10 chain done cycle v%0d restart=%0d (R2 when restart)", k, restart_at),
          32'(cyc[k]), 32'(exp_c[k]));
    end
  endtask

  task automatic test_loaduse();
    int exp_c [NV];
    exp_c[0] = 18; exp_c[1] = 13; exp_c[2] = 11;
    clear_mem();
    im[0] = ins(OPC_LDC, 1, 0, 0, 20);
    im[1] = ins(OPC_LOAD, 2, 1, 0, 0);
    im[2] = ins(OPC_ADD, 3, 2, 2, 0);
    im[3] = ins(OPC_STORE, 0, 0, 3, 0);
    im[4] = ins(OPC_HALT, 0, 0, 0, 0);
    for (int k = 0; k < NV; k++) dm[k][20] = 32'd5;
    do_reset();
    launch(0);
    for (int k = 0; k < NV; k++) begin
      chk($sformatf("R3 Load then Add stored v%0d", k), dm[k][0], 32'd10);
      chk($sformatf("R10 R9 R8 load-use done cycle v%0d", k), 32'(cyc[k]), 32'(exp_c[k]));
    end
  endtask

  task automatic test_memorder();
    clear_mem();
    im[0] = ins(OPC_LDC, 1, 0, 0, 40);
    im[1] = ins(OPC_LDC, 2, 0, 0, 16'h1234);
    im[2] = ins(OPC_STORE, 0, 1, 2, 0);
    im[3] = ins(OPC_LOAD, 3, 1, 0, 0);
    im[4] = ins(OPC_ADD, 4, 3, 3, 0);
    im[5] = ins(OPC_STORE, 0, 0, 4, 0);
    im[6] = ins(OPC_HALT, 0, 0, 0, 0);
    do_reset();
    launch(0);
    for (int k = 0; k < NV; k++) begin
      chk($sformatf("R11 Store data in memory v%0d", k), dm[k][40], 32'h1234);
      chk($sformatf("R11 Load sees prior Store v%0d", k), dm[k][0], 32'h2468);
    end
  endtask

  task automatic test_jz_taken();
    clear_mem();
    im[0] = ins(OPC_LDC, 5, 0, 0, 6);
    im[1] = ins(OPC_JZ, 0, 0, 5, 0);
    im[2] = ins(OPC_HALT, 0, 0, 0, 0);
    im[3] = ins(OPC_STORE, 0, 5, 5, 0);
    im[6] = ins(OPC_LDC, 7, 0, 0, 9);
    im[7] = ins(OPC_STORE, 0, 0, 7, 0);
    im[8] = ins(OPC_HALT, 0, 0, 0, 0);
    do_reset();
    launch(0);
    for (int k = 0; k < NV; k++) begin
      chk($sformatf("R6 target path ran past flushed Halt v%0d", k), dm[k][0], 32'd9);
      chk($sformatf("R6 wrong-path Store discarded v%0d", k), dm[k][6], SENT);
    end
  endtask

  task automatic test_jz_not();
    clear_mem();
    im[0] = ins(OPC_LDC, 1, 0, 0, 3);
    im[1] = ins(OPC_LDC, 2, 0, 0, 9);
    im[2] = ins(OPC_JZ, 0, 1, 2, 0);
    im[3] = ins(OPC_STORE, 0, 0, 1, 0);
    im[4] = ins(OPC_HALT, 0, 0, 0, 0);
    im[9] = ins(OPC_STORE, 0, 2, 2, 0);
    im[10] = ins(OPC_HALT, 0, 0, 0, 0);
    do_reset();
    launch(0);
    for (int k = 0; k < NV; k++) begin
      chk($sformatf("R7 fall-through Store v%0d", k), dm[k][0], 32'd3);
      chk($sformatf("R7 target not executed v%0d", k), dm[k][9], SENT);
    end
  endtask

  initial begin
    #(100000 * 4);
    nchk++;
    nerr++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    clear_mem();
    test_reset();
    test_halt();
    test_chain(0);
    test_chain(3);
    test_loaduse();
    test_memorder();
    test_jz_taken();
    test_jz_not();
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule